// File: doc/BRIEF.md
# Reset Sequencing Controller

This block turns two raw reset requests into a set of timed reset outputs for a chip. One request is an active-low power-on input, which is taken as asynchronous. The other is an active-low hard-reset pin, which is also asynchronous and may carry glitches. All counting runs on a slow, always-on 32 kHz clock. When power-on is released, the block holds the chip in reset for a long settling interval. When the hard-reset pin is used, the block first checks that the low level lasts for some time and discards short pulses.

Once a reset request ends, two stretch counters hold their outputs for a further fixed number of slow cycles. The shorter count drives the reset of the memory controller. The longer count drives the internal system reset and its inverted copy on an output pin. The block also brings the system reset into the fast bus clock domain. There it asserts at once and releases in step with the bus clock. All lengths are parameters, so a simulation can use short values.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_in_n` is low, `mem_rst` and `sys_rst` are 1 and `rst_out_n` and `bus_rst_n` are 0, whatever level `ext_rst_n` has.
- R2: Number the rising `clk_lo` edges from the first one that sees `por_in_n` high. `mem_rst` falls at edge POR_CYCLES+MEM_CYCLES and `sys_rst` falls at edge POR_CYCLES+SYS_CYCLES.
- R3: If `ext_rst_n` is sampled low on fewer than QUAL_CYCLES consecutive `clk_lo` edges, no output changes.
- R4: If `ext_rst_n` is sampled low on N ≥ QUAL_CYCLES consecutive edges, number the edges from the first low sample. `mem_rst` and `sys_rst` then rise at edge QUAL_CYCLES+3.
- R5: After such an N-edge request, `mem_rst` falls at edge N+3+MEM_CYCLES of that same numbering.
- R6: After such an N-edge request, `sys_rst` falls at edge N+3+SYS_CYCLES.
- R7: `rst_out_n` is always the inverse of `sys_rst`.
- R8: A new qualified request, or a power-on reset, that arrives while a stretch is running restarts both stretch counts. Each output is then the union of the windows that R2, R5 and R6 give for each request.
- R9: `bus_rst_n` goes low without waiting for a bus clock edge whenever `sys_rst` is 1. It returns high on the second rising `clk_bus` edge after `sys_rst` falls.
- R10: With MEM_CYCLES ≤ SYS_CYCLES, `mem_rst` is never 1 while `sys_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lo | input | 1 | 32 kHz always-on counting clock |
| clk_bus | input | 1 | fast system bus clock |
| por_in_n | input | 1 | power-on reset request, active low, asynchronous |
| ext_rst_n | input | 1 | hard-reset pin, active low, asynchronous |
| mem_rst | output | 1 | memory-controller reset, active high |
| sys_rst | output | 1 | internal system reset, active high, clk_lo domain |
| rst_out_n | output | 1 | reset pin driven off chip, active low |
| bus_rst_n | output | 1 | system reset in the clk_bus domain, active low |

## Verification
The clocked properties assume that `ext_rst_n` stays high at the edge where `por_in_n` is released. The bench always raises the pin at least two slow edges before that release. The bus-domain property assumes that `clk_bus` runs several times faster than `clk_lo`. The bench uses a 6 ns bus period against a 40 ns slow period, so the bus copy has settled by the next slow falling edge. All pin changes are made a quarter period after a falling `clk_lo` edge. This keeps every edge count in R2 to R6 unambiguous.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_w(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Edge (1-based, from first low sample) at which a qualified pin request asserts the outputs.
  function automatic int unsigned assert_edge(input int unsigned qual, input int unsigned sync);
    return qual + sync + 1;
  endfunction

  // Edge at which a stretch output releases after a request of n low samples.
  function automatic int unsigned release_edge(input int unsigned n, input int unsigned sync,
                                               input int unsigned len);
    return n + sync + 1 + len;
  endfunction

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= {STAGES{RST_VAL}};
    else         stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_por_ext.sv
module rst_por_ext #(
  parameter int unsigned POR_CYCLES = 9600
) (
  input  logic clk,
  input  logic por_n,
  output logic hold
);
  localparam int unsigned W = rst_seq_pkg::cnt_w(POR_CYCLES);
  localparam logic [W-1:0] LAST = W'(POR_CYCLES - 1);

  logic [W-1:0] cnt;
  logic         last_tick;

  assign last_tick = hold && (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else if (hold) begin
      if (last_tick) hold <= 1'b0;
      else           cnt  <= cnt + 1'b1;
    end
  end

  AST_POR_NO_REARM: assert property (@(posedge clk) disable iff (!por_n)
    !hold |=> !hold); // R2
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int unsigned QUAL_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic qual_active
);
  localparam int unsigned W  = rst_seq_pkg::cnt_w(QUAL_CYCLES);
  localparam logic [W-1:0] FULL = W'(QUAL_CYCLES);
  localparam int unsigned WC = rst_seq_pkg::cnt_w(QUAL_CYCLES + 1);
  localparam logic [WC-1:0] CCAP = WC'(QUAL_CYCLES + 1);

  logic         pin_s;
  logic         sync_low;
  logic [W-1:0] cnt;

  rst_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d     (pin_n),
    .q     (pin_s)
  );

  assign sync_low = !pin_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          cnt <= '0;
    else if (!sync_low)   cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign qual_active = (cnt == FULL);

  // checker: length of the current run of low synchronised samples
  logic [WC-1:0] low_run;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             low_run <= '0;
    else if (pin_s)          low_run <= '0;
    else if (low_run != CCAP) low_run <= low_run + 1'b1;
  end

  AST_QUAL_DROPS: assert property (@(posedge clk) disable iff (!arst_n)
    !sync_low |=> !qual_active); // R3
  AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!arst_n)
    qual_active |-> (low_run >= WC'(QUAL_CYCLES))); // R4
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned LEN = 7
) (
  input  logic clk,
  input  logic arst_n,
  input  logic src,
  output logic busy
);
  localparam int unsigned W  = rst_seq_pkg::cnt_w(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);
  localparam int unsigned WI = rst_seq_pkg::cnt_w(LEN + 1);
  localparam logic [WI-1:0] ICAP = WI'(LEN + 1);

  logic [W-1:0] cnt;
  logic         done_tick;

  assign done_tick = busy && !src && (cnt == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (src) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done_tick) busy <= 1'b0;
      else           cnt  <= cnt + 1'b1;
    end
  end

  // checker: cycles since the request source last went quiet
  logic [WI-1:0] idle_run;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              idle_run <= '0;
    else if (src)             idle_run <= '0;
    else if (idle_run != ICAP) idle_run <= idle_run + 1'b1;
  end

  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(busy) |-> (idle_run == WI'(LEN))); // R5 R6
  AST_STRETCH_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
    src |=> busy); // R8
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned POR_CYCLES  = 9600,
  parameter int unsigned QUAL_CYCLES = 4,
  parameter int unsigned MEM_CYCLES  = 7,
  parameter int unsigned SYS_CYCLES  = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BUS_STAGES  = 2
) (
  input  logic clk_lo,
  input  logic clk_bus,
  input  logic por_in_n,
  input  logic ext_rst_n,
  output logic mem_rst,
  output logic sys_rst,
  output logic rst_out_n,
  output logic bus_rst_n
);
  localparam int unsigned NUM_STR = 2;

  logic               por_hold;
  logic               qual_active;
  logic               rst_src;
  logic [NUM_STR-1:0] busy_v;
  logic               sys_arst_n;

  rst_por_ext #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk  (clk_lo),
    .por_n(por_in_n),
    .hold (por_hold)
  );

  rst_qualifier #(.QUAL_CYCLES(QUAL_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk        (clk_lo),
    .arst_n     (por_in_n),
    .pin_n      (ext_rst_n),
    .qual_active(qual_active)
  );

  assign rst_src = por_hold | qual_active;

  // index 0: memory reset, index 1: system reset
  for (genvar g = 0; g < NUM_STR; g++) begin : g_str
    localparam int unsigned L = (g == 0) ? MEM_CYCLES : SYS_CYCLES;
    rst_stretch #(.LEN(L)) u_str (
      .clk   (clk_lo),
      .arst_n(por_in_n),
      .src   (rst_src),
      .busy  (busy_v[g])
    );
  end

  assign mem_rst   = busy_v[0];
  assign sys_rst   = busy_v[1];
  assign rst_out_n = ~busy_v[1];

  assign sys_arst_n = ~sys_rst;

  rst_sync_chain #(.STAGES(BUS_STAGES), .RST_VAL(1'b0)) u_bus (
    .clk   (clk_bus),
    .arst_n(sys_arst_n),
    .d     (1'b1),
    .q     (bus_rst_n)
  );

  AST_POR_ALL_ON: assert property (@(posedge clk_lo) disable iff (!por_in_n)
    por_hold |-> (mem_rst && sys_rst && !rst_out_n)); // R1
  AST_MEM_INSIDE_SYS: assert property (@(posedge clk_lo) disable iff (!por_in_n)
    mem_rst |-> sys_rst); // R10
  AST_BUS_HELD: assert property (@(posedge clk_bus) disable iff (!por_in_n)
    sys_rst |-> !bus_rst_n); // R9
endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int CLK_LO_PERIOD  = 40;
  localparam int CLK_BUS_PERIOD = 6;
  localparam int QTR  = CLK_LO_PERIOD / 4;
  localparam int POR  = 20;
  localparam int QUAL = 4;
  localparam int MEM  = 7;
  localparam int SYS  = 14;
  localparam int SYNC = 2;

  typedef struct {
    int    cyc;
    bit    mem;
    bit    sys;
    string req;
  } exp_t;

  logic clk_lo = 1'b0;
  logic clk_bus = 1'b0;
  logic por_in_n;
  logic ext_rst_n;
  logic mem_rst, sys_rst, rst_out_n, bus_rst_n;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_LO_PERIOD/2) clk_lo = ~clk_lo;
  initial begin
    #1;
    forever #(CLK_BUS_PERIOD/2) clk_bus = ~clk_bus;
  end
  always @(posedge clk_lo) cyc <= cyc + 1;

  rst_seq_ctrl #(.POR_CYCLES(POR), .QUAL_CYCLES(QUAL), .MEM_CYCLES(MEM),
                 .SYS_CYCLES(SYS), .SYNC_STAGES(SYNC), .BUS_STAGES(2)) u_dut (
    .clk_lo   (clk_lo),
    .clk_bus  (clk_bus),
    .por_in_n (por_in_n),
    .ext_rst_n(ext_rst_n),
    .mem_rst  (mem_rst),
    .sys_rst  (sys_rst),
    .rst_out_n(rst_out_n),
    .bus_rst_n(bus_rst_n)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // expected window of a pin request of n low samples, relative offset o (1-based edges)
  function automatic bit ext_win(int o, int n, int len);
    return (n >= QUAL) && (o >= QUAL + SYNC + 1) && (o <= n + SYNC + len);
  endfunction

  // monitor: pops scoreboard items for the current cycle
  always @(negedge clk_lo) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t it;
      it = exp_q.pop_front();
      if (it.cyc < cyc) begin
        check(1'b0, it.req, "stale item", it.cyc, cyc);
      end else begin
        check(mem_rst == it.mem, it.req, "mem_rst", mem_rst, it.mem);
        check(sys_rst == it.sys, it.req, "sys_rst", sys_rst, it.sys);
        check(rst_out_n == !it.sys, "R7", "rst_out_n", rst_out_n, !it.sys);
        check(bus_rst_n == !it.sys, "R9", "bus_rst_n", bus_rst_n, !it.sys);
        check(!(mem_rst && !sys_rst), "R10", "mem without sys", mem_rst, 0);
      end
    end
  end

  task automatic hold_pin(bit v, int n);
    ext_rst_n = v;
    repeat (n) @(posedge clk_lo);
    @(negedge clk_lo);
    #(QTR);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk_lo);
    #(QTR);
  endtask

  // push the expectation of a power-on pulse starting at base cycle c (h edges low)
  task automatic push_por(int c, int h, string req);
    for (int k = 1; k <= h; k++) exp_q.push_back('{c + k, 1'b1, 1'b1, "R1"});
    for (int k = 1; k <= POR + SYS + 3; k++)
      exp_q.push_back('{c + h + k, k <= POR + MEM - 1, k <= POR + SYS - 1, req});
  endtask

  task automatic por_pulse(int h, bit pin_low, string req);
    @(negedge clk_lo);
    #(QTR);
    push_por(cyc, h, req);
    por_in_n = 1'b0;
    hold_pin(!pin_low, h - 2);
    hold_pin(1'b1, 2);
    por_in_n = 1'b1;
    drain();
  endtask

  // one or two pin requests: n1 low, gap high, n2 low
  task automatic ext_pulses(int n1, int gap, int n2, string req);
    int c0, g, span;
    @(negedge clk_lo);
    #(QTR);
    c0 = cyc;
    g = n1 + gap;
    span = g + n2 + SYS + 12;
    for (int k = 1; k <= span; k++) begin
      bit m, s;
      m = ext_win(k, n1, MEM) || (n2 > 0 && ext_win(k - g, n2, MEM));
      s = ext_win(k, n1, SYS) || (n2 > 0 && ext_win(k - g, n2, SYS));
      exp_q.push_back('{c0 + k, m, s, req});
    end
    hold_pin(1'b0, n1);
    if (n2 > 0) begin
      hold_pin(1'b1, gap);
      hold_pin(1'b0, n2);
    end
    ext_rst_n = 1'b1;
    drain();
  endtask

  // power-on reset arriving in the middle of a pin-triggered stretch
  task automatic por_mid_stretch();
    int c0;
    @(negedge clk_lo);
    #(QTR);
    c0 = cyc;
    for (int k = 1; k <= 15; k++)
      exp_q.push_back('{c0 + k, ext_win(k, 5, MEM), ext_win(k, 5, SYS), "R8"});
    push_por(c0 + 15, 4, "R8");
    hold_pin(1'b0, 5);
    hold_pin(1'b1, 10);
    por_in_n = 1'b0;
    hold_pin(1'b1, 4);
    por_in_n = 1'b1;
    drain();
  endtask

  initial begin
    por_in_n  = 1'b1;
    ext_rst_n = 1'b1;
    #1 por_in_n = 1'b0;
    ext_rst_n = 1'b0;
    @(negedge clk_lo);
    // reset state, pin low during power-on
    check(mem_rst == 1'b1, "R1", "mem_rst reset", mem_rst, 1);
    check(sys_rst == 1'b1, "R1", "sys_rst reset", sys_rst, 1);
    check(rst_out_n == 1'b0, "R1", "rst_out_n reset", rst_out_n, 0);
    check(bus_rst_n == 1'b0, "R1", "bus_rst_n reset", bus_rst_n, 0);
    por_pulse(6, 1'b1, "R2");           // R1 R2: release after power-on
    ext_pulses(3, 0, 0, "R3");          // short pulse ignored
    ext_pulses(1, 0, 0, "R3");
    ext_pulses(2, 2, 3, "R3");          // two short pulses, no accumulation
    ext_pulses(4, 0, 0, "R4");          // exactly the qualifier window
    ext_pulses(10, 0, 0, "R5/R6");      // long request, both stretches
    ext_pulses(5, 6, 4, "R8");          // second request during system stretch
    por_mid_stretch();                  // R8 power-on during a stretch
    por_pulse(5, 1'b0, "R2");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_LO_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule